// File: doc/BRIEF.md
# NAND Page Hamming ECC Engine

This block observes the data bus of a NAND flash device and builds a Hamming-style parity code over the whole data area of a page as a single codeword. It does not process the page in smaller sub-blocks. When a page is programmed, software streams the data past the engine and then reads a 4-byte code from two parity registers. That code is stored in the spare area.

On a page read, the data strobes are followed directly by the stored code bytes. The engine forms a syndrome from the stored code and its own parity, then sorts the result into one of four cases:
- no error;
- a single correctable data-bit error, reported with its unit address and bit offset;
- a single-bit error inside the stored code;
- an uncorrectable multi-bit error.

A freshly erased page (all ones, including the code) shows up as a multi-bit error whose location field is all ones. Software is expected to recognise that pattern and treat the page as clean.

A mode register selects the total page size (528, 1056, 2112 or 4224 bytes, of which 512 << size are data) and the bus width (8 or 16 bits). A control bit clears the engine before each page pass.

Top module: `ecc_engine`

## Requirements
- R1: After reset, the MODE, STAT, PAR0 and PAR1 registers all read zero.
- R2: The location of a data bit is L = unit_index*16 + bit_index. PAR0[15:0] holds the XOR of all set data bits over the L bits that are 1 (code bytes 0 and 1, low byte first). PAR1[15:0] holds the same XOR over the L bits that are 0 (code bytes 2 and 3). PAR1[31:16] reads zero.
- R3: When the stored code equals the computed code, STAT reads 0 after the last code byte.
- R4: The syndrome is computed XOR stored. If its two 16-bit halves are exact complements, STAT reads 1 (bit0 = error) and PAR0[15:0] gives the flipped bit's location: bit offset in [3:0] and unit address in [15:4].
- R5: A syndrome with exactly one set bit means an error in the code bytes. STAT reads 3 (bit1 = code error, plus bit0).
- R6: Any other nonzero syndrome means a multi-bit error. STAT reads 5 (bit2 = multiple, plus bit0). The code-error and multiple flags are never set together.
- R7: An all-ones page with an all-ones stored code gives STAT = 5 and PAR0[15:0] = 16'hFFFF. Writing the same page gives PAR0 = PAR1 = 0.
- R8: MODE[2] = 1 selects the 16-bit bus, where a unit is a 16-bit word, the bit offset is 0..15, and the 4 code bytes arrive in two strobes (low byte in bits [7:0]). MODE[2] = 0 selects the 8-bit bus: only bus_data[7:0] is used, and the code takes four strobes.
- R9: MODE[1:0] = s gives 512 << s data bytes. The data strobes are followed by the code strobes, and the status becomes valid only on the last code strobe. The code strobes do not change PAR0 or PAR1.
- R10: Writing CTRL (address 0) with bit0 set clears the parity accumulators, the stored code, the strobe count and STAT. MODE is left unchanged.
- R11: Once the check is complete, further strobes are ignored until the next clear.
- R12: A read (reg_rd) returns reg_rdata with reg_rvalid exactly one cycle later. The register addresses are 0 CTRL, 1 MODE, 2 STAT, 3 PAR0 and 4 PAR1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| reg_wr | input | 1 | Register write strobe |
| reg_rd | input | 1 | Register read request |
| reg_addr | input | 3 | Register address |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Register read data |
| reg_rvalid | output | 1 | Read data valid, one cycle after reg_rd |
| bus_stb | input | 1 | One data unit present on the NAND bus |
| bus_data | input | 16 | NAND bus data; bits [15:8] unused in 8-bit mode |

## Verification
The accumulators update on the clock edge that samples each data strobe. Status and the error location become valid on the edge that samples the last code strobe. A register read returns its value on the edge after reg_rd.

The bench issues reads only after the strobes of a pass have been clocked in. It queues each expected value when the read is requested, and the monitor compares the value on the falling edge while reg_rvalid is high. A result that arrives a cycle early or late therefore pairs with the wrong entry in the queue. The status-boundary case reads STAT between the third and fourth code strobe to pin down the exact cycle.

// File: rtl/ecc_pkg.sv
package ecc_pkg;

    parameter int BASE_DATA_BYTES = 512;
    parameter int MAX_SHIFT       = 3;
    parameter int BUS_W           = 16;
    parameter int CODE_BYTES      = 4;

    localparam int MAX_DATA_BYTES = BASE_DATA_BYTES << MAX_SHIFT;
    localparam int ADDR_W = $clog2(MAX_DATA_BYTES);
    localparam int BIT_W  = $clog2(BUS_W);
    localparam int LOC_W  = ADDR_W + BIT_W;
    localparam int CNT_W  = $clog2(MAX_DATA_BYTES + CODE_BYTES + 1);

    localparam logic [2:0] RA_CTRL = 3'd0;
    localparam logic [2:0] RA_MODE = 3'd1;
    localparam logic [2:0] RA_STAT = 3'd2;
    localparam logic [2:0] RA_PAR0 = 3'd3;
    localparam logic [2:0] RA_PAR1 = 3'd4;

    typedef enum logic [1:0] {PG_528, PG_1056, PG_2112, PG_4224} page_sel_e;
    typedef enum logic [1:0] {PH_DATA, PH_CODE, PH_DONE} phase_e;

    typedef struct packed {
        logic      wide;
        page_sel_e size;
    } mode_t;

    typedef struct packed {
        logic multi;
        logic code_err;
        logic err;
    } stat_t;

    typedef struct packed {
        logic [LOC_W-1:0] zeros;
        logic [LOC_W-1:0] ones;
    } code_t;

    function automatic logic [CNT_W-1:0] data_units(mode_t m);
        int bytes;
        bytes = BASE_DATA_BYTES << int'(m.size);
        return m.wide ? CNT_W'(bytes / 2) : CNT_W'(bytes);
    endfunction

    function automatic logic [CNT_W-1:0] code_units(logic wide);
        return wide ? CNT_W'(CODE_BYTES / 2) : CNT_W'(CODE_BYTES);
    endfunction

    function automatic logic [BUS_W-1:0] lane_mask(int k);
        logic [BUS_W-1:0] m;
        for (int b = 0; b < BUS_W; b++) m[b] = ((b >> k) & 1) == 1;
        return m;
    endfunction

endpackage

// File: rtl/ecc_unit_counter.sv
module ecc_unit_counter
    import ecc_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              clear,
    input  logic              stb,
    input  mode_t             mode,
    output phase_e            phase,
    output logic [ADDR_W-1:0] unit_idx,
    output logic [1:0]        slot
);
    logic [CNT_W-1:0] cnt_q;
    logic [CNT_W-1:0] du;
    logic [CNT_W-1:0] total;
    logic [1:0]       slot_q;

    always_comb begin
        du    = data_units(mode);
        total = du + code_units(mode.wide);
        if (cnt_q < du)         phase = PH_DATA;
        else if (cnt_q < total) phase = PH_CODE;
        else                    phase = PH_DONE;
    end

    always_ff @(posedge clk) begin
        if (rst || clear) begin
            cnt_q  <= '0;
            slot_q <= '0;
        end else if (stb && phase != PH_DONE) begin
            cnt_q <= cnt_q + 1'b1;
            if (phase == PH_CODE) slot_q <= slot_q + 1'b1;
        end
    end

    assign unit_idx = cnt_q[ADDR_W-1:0];
    assign slot     = slot_q;
endmodule

// File: rtl/ecc_parity_accum.sv
module ecc_parity_accum
    import ecc_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              clear,
    input  logic              en,
    input  logic [ADDR_W-1:0] idx,
    input  logic [BUS_W-1:0]  d,
    output code_t             code
);
    logic [BIT_W-1:0] col1, col0;
    logic             row;
    code_t            acc_q;

    for (genvar k = 0; k < BIT_W; k++) begin : g_col
        assign col1[k] = ^(d & lane_mask(k));
        assign col0[k] = ^(d & ~lane_mask(k));
    end
    assign row = ^d;

    always_ff @(posedge clk) begin
        if (rst || clear) begin
            acc_q <= '0;
        end else if (en) begin
            acc_q.ones  <= acc_q.ones  ^ {idx & {ADDR_W{row}}, col1};
            acc_q.zeros <= acc_q.zeros ^ {~idx & {ADDR_W{row}}, col0};
        end
    end

    assign code = acc_q;
endmodule

// File: rtl/ecc_check_eval.sv
module ecc_check_eval
    import ecc_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  logic             clear,
    input  logic             cap_en,
    input  logic             wide,
    input  logic [1:0]       slot,
    input  logic [BUS_W-1:0] d,
    input  logic             done,
    input  code_t            calc,
    output code_t            syndrome,
    output stat_t            stat
);
    logic [2*LOC_W-1:0] stored_q;
    logic               nonzero, single, onebit;

    always_ff @(posedge clk) begin
        if (rst || clear) begin
            stored_q <= '0;
        end else if (cap_en) begin
            if (wide) stored_q[{slot[0], 4'b0000} +: 16] <= d;
            else      stored_q[{slot, 3'b000} +: 8]     <= d[7:0];
        end
    end

    always_comb begin
        syndrome      = calc ^ code_t'(stored_q);
        nonzero       = |syndrome;
        single        = (syndrome.ones == ~syndrome.zeros);
        onebit        = ($countones(syndrome) == 1);
        stat.err      = done && nonzero;
        stat.code_err = done && nonzero && !single && onebit;
        stat.multi    = done && nonzero && !single && !onebit;
    end
endmodule

// File: rtl/ecc_engine.sv
module ecc_engine
    import ecc_pkg::*;
(
    input  logic        clk,
    input  logic        rst,
    input  logic        reg_wr,
    input  logic        reg_rd,
    input  logic [2:0]  reg_addr,
    input  logic [31:0] reg_wdata,
    output logic [31:0] reg_rdata,
    output logic        reg_rvalid,
    input  logic        bus_stb,
    input  logic [15:0] bus_data
);
    mode_t             mode_q;
    logic              clear_pg, mode_wr;
    phase_e            phase;
    logic [ADDR_W-1:0] unit_idx;
    logic [1:0]        slot;
    logic [BUS_W-1:0]  bus_d;
    code_t             calc_code, syndrome;
    stat_t             stat;
    logic [31:0]       rd_mux, rdata_q;
    logic              rvalid_q;
    logic [LOC_W-1:0]  par0;

    assign clear_pg = reg_wr && reg_addr == RA_CTRL && reg_wdata[0];
    assign mode_wr  = reg_wr && reg_addr == RA_MODE;
    assign bus_d    = mode_q.wide ? bus_data : {8'h00, bus_data[7:0]};

    ecc_unit_counter u_cnt (
        .clk(clk), .rst(rst), .clear(clear_pg), .stb(bus_stb),
        .mode(mode_q), .phase(phase), .unit_idx(unit_idx), .slot(slot)
    );

    ecc_parity_accum u_acc (
        .clk(clk), .rst(rst), .clear(clear_pg),
        .en(bus_stb && phase == PH_DATA), .idx(unit_idx),
        .d(bus_d), .code(calc_code)
    );

    ecc_check_eval u_eval (
        .clk(clk), .rst(rst), .clear(clear_pg),
        .cap_en(bus_stb && phase == PH_CODE), .wide(mode_q.wide),
        .slot(slot), .d(bus_d), .done(phase == PH_DONE),
        .calc(calc_code), .syndrome(syndrome), .stat(stat)
    );

    always_ff @(posedge clk) begin
        if (rst)          mode_q <= '0;
        else if (mode_wr) mode_q <= mode_t'(reg_wdata[2:0]);
    end

    assign par0 = stat.err ? syndrome.ones : calc_code.ones;

    always_comb begin
        case (reg_addr)
            RA_MODE: rd_mux = {29'b0, mode_q};
            RA_STAT: rd_mux = {29'b0, stat};
            RA_PAR0: rd_mux = {16'b0, par0};
            RA_PAR1: rd_mux = {16'b0, calc_code.zeros};
            default: rd_mux = '0;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            rdata_q  <= '0;
            rvalid_q <= 1'b0;
        end else begin
            rvalid_q <= reg_rd;
            if (reg_rd) rdata_q <= rd_mux;
        end
    end

    assign reg_rdata  = rdata_q;
    assign reg_rvalid = rvalid_q;
endmodule

// File: rtl/ecc_engine_chk.sv
module ecc_engine_chk
    import ecc_pkg::*;
(
    input logic   clk,
    input logic   rst,
    input logic   clear,
    input logic   mode_wr,
    input logic   reg_rd,
    input logic   reg_rvalid,
    input phase_e phase,
    input stat_t  stat,
    input code_t  acc
);
    // R12
    rvalid_timing_chk: assert property (@(posedge clk) disable iff (rst)
        reg_rd |=> reg_rvalid);
    // R12
    rvalid_quiet_chk: assert property (@(posedge clk) disable iff (rst)
        !reg_rd |=> !reg_rvalid);
    // R10
    clear_zeroes_chk: assert property (@(posedge clk) disable iff (rst)
        clear |=> (acc == '0 && phase == PH_DATA && stat == '0));
    // R11
    done_frozen_chk: assert property (@(posedge clk) disable iff (rst)
        (phase == PH_DONE && !clear && !mode_wr) |=> ($stable(acc) && $stable(stat)));
    // R9
    code_phase_hold_chk: assert property (@(posedge clk) disable iff (rst)
        (phase == PH_CODE && !clear) |=> $stable(acc));
    // R6
    flags_exclusive_chk: assert property (@(posedge clk) disable iff (rst)
        !(stat.code_err && stat.multi));
    // R3
    err_after_done_chk: assert property (@(posedge clk) disable iff (rst)
        stat.err |-> phase == PH_DONE);
endmodule

bind ecc_engine ecc_engine_chk chk_i (
    .clk(clk), .rst(rst), .clear(clear_pg), .mode_wr(mode_wr),
    .reg_rd(reg_rd), .reg_rvalid(reg_rvalid), .phase(phase),
    .stat(stat), .acc(calc_code)
);

// File: tb/ecc_engine_tb.sv
module ecc_engine_tb_top;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        reg_wr = 1'b0, reg_rd = 1'b0;
    logic [2:0]  reg_addr = '0;
    logic [31:0] reg_wdata = '0;
    logic [31:0] reg_rdata;
    logic        reg_rvalid;
    logic        bus_stb = 1'b0;
    logic [15:0] bus_data = '0;

    int compared = 0, mismatched = 0;
    bit finished = 0;
    logic [31:0] exp_q[$];
    string       tag_q[$];
    logic [15:0] pg [0:4095];

    always #5 clk = ~clk;

    ecc_engine dut_i (
        .clk(clk), .rst(rst), .reg_wr(reg_wr), .reg_rd(reg_rd),
        .reg_addr(reg_addr), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
        .reg_rvalid(reg_rvalid), .bus_stb(bus_stb), .bus_data(bus_data)
    );

    // monitor: pop one expected item per returned read
    always @(negedge clk) begin
        if (reg_rvalid) begin
            if (exp_q.size() == 0) begin
                mismatched++;
                $display("FAIL R12 unexpected read data act=%h exp=none", reg_rdata);
            end else begin
                logic [31:0] e;
                string t;
                e = exp_q.pop_front();
                t = tag_q.pop_front();
                compared++;
                if (reg_rdata !== e) begin
                    mismatched++;
                    $display("FAIL %s act=%h exp=%h", t, reg_rdata, e);
                end
            end
        end
    end

    task automatic reg_write(input logic [2:0] a, input logic [31:0] v);
        reg_wr = 1'b1; reg_addr = a; reg_wdata = v;
        @(negedge clk);
        reg_wr = 1'b0;
    endtask

    task automatic expect_reg(input logic [2:0] a, input logic [31:0] v, input string tag);
        exp_q.push_back(v);
        tag_q.push_back(tag);
        reg_rd = 1'b1; reg_addr = a;
        @(negedge clk);
        reg_rd = 1'b0;
    endtask

    task automatic stream_units(input int n);
        for (int i = 0; i < n; i++) begin
            bus_stb = 1'b1; bus_data = pg[i];
            @(negedge clk);
        end
        bus_stb = 1'b0;
    endtask

    task automatic send_code(input logic [31:0] c, input bit wide, input int first, input int count);
        for (int j = first; j < first + count; j++) begin
            bus_stb = 1'b1;
            bus_data = wide ? c[16*j +: 16] : {8'hA5, c[8*j +: 8]};
            @(negedge clk);
        end
        bus_stb = 1'b0;
    endtask

    function automatic logic [31:0] model_code(input int n, input bit wide);
        logic [15:0] ones = '0, zeros = '0;
        for (int i = 0; i < n; i++)
            for (int b = 0; b < (wide ? 16 : 8); b++)
                if (pg[i][b]) begin
                    logic [15:0] loc;
                    loc = 16'(i * 16 + b);
                    for (int k = 0; k < 16; k++)
                        if (loc[k]) ones[k] = ~ones[k]; else zeros[k] = ~zeros[k];
                end
        return {zeros, ones};
    endfunction

    task automatic fill(input int seed);
        for (int i = 0; i < 4096; i++) pg[i] = 16'(i * 40503 + seed) ^ 16'(i >> 3);
    endtask

    task automatic start(input logic [2:0] m);
        reg_write(3'd1, {29'b0, m});
        reg_write(3'd0, 32'h1);
    endtask

    task automatic summary;
        if (!finished) begin
            finished = 1;
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
            $finish;
        end
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        mismatched++;
        $display("FAIL watchdog act=running exp=finished");
        summary();
    end

    initial begin
        logic [31:0] c;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);

        // R1 reset state, R12 read timing
        expect_reg(3'd1, 0, "R1 MODE after reset");
        expect_reg(3'd2, 0, "R1 STAT after reset");
        expect_reg(3'd3, 0, "R1 PAR0 after reset");
        expect_reg(3'd4, 0, "R1 PAR1 after reset");

        // R2 write pass, 8-bit, 512 bytes, upper bus byte carries junk (R8)
        fill(11);
        c = model_code(512, 0);
        start(3'b000);
        stream_units(512);
        expect_reg(3'd3, {16'b0, c[15:0]}, "R2 PAR0 after write");
        expect_reg(3'd4, {16'b0, c[31:16]}, "R2 PAR1 after write");

        // R3 clean read
        start(3'b000);
        stream_units(512);
        send_code(c, 0, 0, 4);
        expect_reg(3'd2, 0, "R3 STAT clean");
        expect_reg(3'd3, {16'b0, c[15:0]}, "R3 PAR0 clean");

        // R4 single data error at byte 300 bit 5
        pg[300][5] = ~pg[300][5];
        start(3'b000);
        stream_units(512);
        send_code(c, 0, 0, 4);
        expect_reg(3'd2, 1, "R4 STAT single");
        expect_reg(3'd3, 32'h12C5, "R4 PAR0 location");
        pg[300][5] = ~pg[300][5];

        // R5 single bit error in the code bytes
        start(3'b000);
        stream_units(512);
        send_code(c ^ 32'h200, 0, 0, 4);
        expect_reg(3'd2, 3, "R5 STAT code error");

        // R6 two data errors
        pg[10][1] = ~pg[10][1];
        pg[77][6] = ~pg[77][6];
        start(3'b000);
        stream_units(512);
        send_code(c, 0, 0, 4);
        expect_reg(3'd2, 5, "R6 STAT multiple");

        // R7 erased page
        for (int i = 0; i < 4096; i++) pg[i] = 16'hFFFF;
        start(3'b000);
        stream_units(512);
        expect_reg(3'd3, 0, "R7 PAR0 erased write");
        expect_reg(3'd4, 0, "R7 PAR1 erased write");
        start(3'b000);
        stream_units(512);
        send_code(32'hFFFF_FFFF, 0, 0, 4);
        expect_reg(3'd2, 5, "R7 STAT erased");
        expect_reg(3'd3, 32'hFFFF, "R7 PAR0 erased");

        // R8 16-bit bus, 1024 data bytes = 512 words, error word 200 bit 13
        fill(5);
        c = model_code(512, 1);
        start(3'b101);
        stream_units(512);
        expect_reg(3'd3, {16'b0, c[15:0]}, "R8 PAR0 wide write");
        expect_reg(3'd4, {16'b0, c[31:16]}, "R8 PAR1 wide write");
        pg[200][13] = ~pg[200][13];
        start(3'b101);
        stream_units(512);
        send_code(c, 1, 0, 2);
        expect_reg(3'd2, 1, "R8 STAT wide single");
        expect_reg(3'd3, 32'h0C8D, "R8 PAR0 wide location");

        // R9 4096-byte page, error on last data bit
        fill(29);
        c = model_code(4096, 0);
        pg[4095][7] = ~pg[4095][7];
        start(3'b011);
        stream_units(4096);
        send_code(c, 0, 0, 4);
        expect_reg(3'd2, 1, "R9 STAT largest page");
        expect_reg(3'd3, 32'hFFF7, "R9 PAR0 largest page");

        // R9 status only after the last code strobe, 2048-byte page
        fill(3);
        c = model_code(2048, 0);
        pg[1000][0] = ~pg[1000][0];
        start(3'b010);
        stream_units(2048);
        send_code(c, 0, 0, 3);
        expect_reg(3'd2, 0, "R9 STAT before last code byte");
        send_code(c, 0, 3, 1);
        expect_reg(3'd2, 1, "R9 STAT after last code byte");
        expect_reg(3'd3, 32'h3E80, "R9 PAR0 location");

        // R11 extra strobes ignored
        send_code(32'h1234_5678, 0, 0, 4);
        expect_reg(3'd2, 1, "R11 STAT after extra strobes");
        expect_reg(3'd3, 32'h3E80, "R11 PAR0 after extra strobes");

        // R10 clear
        reg_write(3'd0, 32'h1);
        expect_reg(3'd2, 0, "R10 STAT after clear");
        expect_reg(3'd3, 0, "R10 PAR0 after clear");
        expect_reg(3'd4, 0, "R10 PAR1 after clear");
        expect_reg(3'd1, 32'h2, "R10 MODE kept");

        repeat (3) @(negedge clk);
        if (exp_q.size() != 0) begin
            mismatched++;
            $display("FAIL R12 missing reads act=%0d exp=0", exp_q.size());
        end
        summary();
    end
endmodule